// File: doc/BRIEF.md
# Unaligned Two-Bank Byte Memory Steering

This block sits in front of two byte-wide synchronous memory banks and makes them look like one byte-addressable memory that takes 8-bit and 16-bit accesses at any byte address, aligned or not. Bit 0 of the byte address picks the bank that holds that byte: even addresses live in bank 0 and odd addresses in bank 1. A 16-bit access covers the byte at the given address, which is the most significant half of the word, and the byte at the next address, which is the least significant half. When the address is odd, the two halves land in swapped banks and on different bank rows.

The request side presents a byte address, a size bit, a write strobe and a request, plus separate 16-bit write and read data buses. The block derives from these a row, a chip select and a write enable for each bank. It routes the write bytes to the banks and assembles the bank outputs into the read word. Byte values always use the low data lines. The control and write paths are combinational. The read word is produced in the cycle after the request, when the synchronous banks deliver their data.

Top module: `dbs_top`

## Requirements
- R1: The size input uses 0 for an 8-bit access and 1 for a 16-bit access. With a request present, an 8-bit access asserts the chip select of bank addr[0] only (0 means bank 0, 1 means bank 1), and a 16-bit access asserts both chip selects.
- R2: While req is 0, neither bank sees chip select or write enable, and the bank contents are left unchanged.
- R3: Both bank rows equal addr shifted right by one. The one exception is a 16-bit access at an odd address, where bank 0's row is that value plus one.
- R4: On a 16-bit write to an even address, wdata[15:8] goes to bank 0 and wdata[7:0] goes to bank 1.
- R5: On a 16-bit write to an odd address, wdata[15:8] goes to bank 1 and wdata[7:0] goes to bank 0.
- R6: On an 8-bit write, the selected bank receives wdata[7:0], and wdata[15:8] has no effect on any stored byte.
- R7: A bank's write enable is asserted exactly when that bank is chip-selected and wr is 1. A value of wr = 0 means read.
- R8: The cycle after a 16-bit read, rdata holds the byte at the address in bits 15:8 and the byte at the address plus one in bits 7:0. For an even address this is {bank 0, bank 1}; for an odd address it is {bank 1, bank 0}.
- R9: The cycle after an 8-bit read, rdata[7:0] holds the byte from bank addr[0] and rdata[15:8] is zero.
- R10: In the cycle after a cycle with no read request (req = 0, or a write), rdata is zero.
- R11: A 16-bit access at the highest byte address wraps: bank 1 uses the top row and bank 0 uses row zero.
- R12: During reset and in the first cycle after it, rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request |
| wr | input | 1 | 1 = write, 0 = read |
| size | input | 1 | 0 = byte, 1 = 16-bit |
| addr | input | ADDR_W | Byte address |
| wdata | input | 2*LANE_W | Write data, byte on low lane |
| rdata | output | 2*LANE_W | Read data, valid the cycle after the request |
| b0_row | output | ADDR_W-1 | Bank 0 row |
| b0_cs | output | 1 | Bank 0 chip select |
| b0_we | output | 1 | Bank 0 write enable |
| b0_wdata | output | LANE_W | Bank 0 write byte |
| b0_rdata | input | LANE_W | Bank 0 read byte |
| b1_row | output | ADDR_W-1 | Bank 1 row |
| b1_cs | output | 1 | Bank 1 chip select |
| b1_we | output | 1 | Bank 1 write enable |
| b1_wdata | output | LANE_W | Bank 1 write byte |
| b1_rdata | input | LANE_W | Bank 1 read byte |

## Verification
The bench builds the block with ADDR_W = 6 and LANE_W = 8. With these values each bank has only 32 rows, so the top byte address 0x3F and the wrap of bank 0 to row zero are reached in a single vector. It can also read the wrapped word back through the bank models. An 8-bit lane keeps the hand-computed expected words easy to read, and it still exercises the swap between the upper and lower lanes for every mix of address parity and size.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

   typedef enum logic {
      ACC_BYTE = 1'b0,
      ACC_HALF = 1'b1
   } acc_size_e;

   typedef struct packed {
      logic pend;
      logic half;
      logic odd;
   } rd_ctl_t;

   localparam int NUM_BANKS = 2;

endpackage

// File: rtl/dbs_decode.sv
module dbs_decode #(
   parameter int ADDR_W = 16
) (
   input  logic                                  req,
   input  logic                                  wr,
   input  logic                                  half,
   input  logic [ADDR_W-1:0]                     addr,
   output logic [dbs_pkg::NUM_BANKS-1:0][ADDR_W-2:0] row,
   output logic [dbs_pkg::NUM_BANKS-1:0]         cs,
   output logic [dbs_pkg::NUM_BANKS-1:0]         we
);
   localparam int ROW_W = ADDR_W - 1;

   logic [ROW_W-1:0] base_row;
   logic             odd;

   assign base_row = addr[ADDR_W-1:1];
   assign odd      = addr[0];

   for (genvar b = 0; b < dbs_pkg::NUM_BANKS; b++) begin : g_bank
      if (b == 0) begin : g_even
         // Bank 0 carries the second byte of an odd 16-bit access: next row.
         assign row[b] = base_row + ROW_W'(half & odd);
      end else begin : g_odd
         assign row[b] = base_row;
      end
      assign cs[b] = req & (half | (odd == 1'(b)));
      assign we[b] = cs[b] & wr;
   end

endmodule

// File: rtl/dbs_wr_lane.sv
module dbs_wr_lane #(
   parameter int LANE_W = 8
) (
   input  logic                                  half,
   input  logic                                  odd,
   input  logic [2*LANE_W-1:0]                   wdata,
   output logic [dbs_pkg::NUM_BANKS-1:0][LANE_W-1:0] bwd
);
   logic [LANE_W-1:0] hi_lane;
   logic [LANE_W-1:0] lo_lane;

   assign hi_lane = wdata[2*LANE_W-1:LANE_W];
   assign lo_lane = wdata[LANE_W-1:0];

   for (genvar b = 0; b < dbs_pkg::NUM_BANKS; b++) begin : g_lane
      // The bank at the start address takes the upper lane of a 16-bit word.
      assign bwd[b] = (half && (odd == 1'(b))) ? hi_lane : lo_lane;
   end

endmodule

// File: rtl/dbs_rd_gather.sv
module dbs_rd_gather #(
   parameter int LANE_W = 8
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  req,
   input  logic                                  wr,
   input  logic                                  half,
   input  logic                                  odd,
   input  logic [dbs_pkg::NUM_BANKS-1:0][LANE_W-1:0] brd,
   output logic [2*LANE_W-1:0]                   rdata
);
   import dbs_pkg::*;

   rd_ctl_t ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else begin
         ctl_q.pend <= req & ~wr;
         ctl_q.half <= half;
         ctl_q.odd  <= odd;
      end
   end

   logic [LANE_W-1:0] first_b;
   logic [LANE_W-1:0] second_b;

   assign first_b  = ctl_q.odd ? brd[1] : brd[0];
   assign second_b = ctl_q.odd ? brd[0] : brd[1];

   always_comb begin
      if (!ctl_q.pend) begin
         rdata = '0;
      end else if (ctl_q.half) begin
         rdata = {first_b, second_b};
      end else begin
         rdata = {{LANE_W{1'b0}}, first_b};
      end
   end

endmodule

// File: rtl/dbs_top.sv
module dbs_top #(
   parameter int ADDR_W = 16,
   parameter int LANE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req,
   input  logic                wr,
   input  logic                size,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [2*LANE_W-1:0] wdata,
   output logic [2*LANE_W-1:0] rdata,
   output logic [ADDR_W-2:0]   b0_row,
   output logic                b0_cs,
   output logic                b0_we,
   output logic [LANE_W-1:0]   b0_wdata,
   input  logic [LANE_W-1:0]   b0_rdata,
   output logic [ADDR_W-2:0]   b1_row,
   output logic                b1_cs,
   output logic                b1_we,
   output logic [LANE_W-1:0]   b1_wdata,
   input  logic [LANE_W-1:0]   b1_rdata
);
   import dbs_pkg::*;

   localparam int ROW_W  = ADDR_W - 1;
   localparam int WORD_W = 2 * LANE_W;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("dbs_top: ADDR_W must be at least 2");
   end
   if (LANE_W < 1) begin : g_bad_lane
      $error("dbs_top: LANE_W must be at least 1");
   end

   acc_size_e acc;
   logic      half;

   assign acc  = acc_size_e'(size);
   assign half = (acc == ACC_HALF);

   logic [NUM_BANKS-1:0][ROW_W-1:0]  row_v;
   logic [NUM_BANKS-1:0]             cs_v;
   logic [NUM_BANKS-1:0]             we_v;
   logic [NUM_BANKS-1:0][LANE_W-1:0] bwd_v;
   logic [NUM_BANKS-1:0][LANE_W-1:0] brd_v;

   dbs_decode #(.ADDR_W(ADDR_W)) u_decode (
      .req  (req),
      .wr   (wr),
      .half (half),
      .addr (addr),
      .row  (row_v),
      .cs   (cs_v),
      .we   (we_v)
   );

   dbs_wr_lane #(.LANE_W(LANE_W)) u_wr_lane (
      .half  (half),
      .odd   (addr[0]),
      .wdata (wdata),
      .bwd   (bwd_v)
   );

   assign brd_v[0] = b0_rdata;
   assign brd_v[1] = b1_rdata;

   dbs_rd_gather #(.LANE_W(LANE_W)) u_rd_gather (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .wr    (wr),
      .half  (half),
      .odd   (addr[0]),
      .brd   (brd_v),
      .rdata (rdata)
   );

   assign b0_row   = row_v[0];
   assign b0_cs    = cs_v[0];
   assign b0_we    = we_v[0];
   assign b0_wdata = bwd_v[0];
   assign b1_row   = row_v[1];
   assign b1_cs    = cs_v[1];
   assign b1_we    = we_v[1];
   assign b1_wdata = bwd_v[1];

   // R2: no request, no bank activity
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req |-> (!b0_cs && !b1_cs && !b0_we && !b1_we));

   // R1: a byte access touches exactly one bank
   a_r1_byte_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !size) |-> ($countones({b1_cs, b0_cs}) == 1));

   // R3: odd 16-bit access puts bank 0 one row beyond bank 1
   a_r3_odd_row_step: assert property (@(posedge clk) disable iff (!rst_n)
      (req && size && addr[0]) |-> (b0_row == ROW_W'(b1_row + 1'b1)));

   // R5: odd 16-bit write sends the upper lane to bank 1
   a_r5_odd_split: assert property (@(posedge clk) disable iff (!rst_n)
      (req && wr && size && addr[0]) |->
         (b1_wdata == wdata[WORD_W-1:LANE_W] && b0_wdata == wdata[LANE_W-1:0]));

   // R9: byte read leaves the upper half of rdata at zero
   a_r9_byte_read_upper: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !wr && !size) |=> (rdata[WORD_W-1:LANE_W] == '0));

   // R10: no read last cycle, no read data now
   a_r10_quiet_rdata: assert property (@(posedge clk) disable iff (!rst_n)
      (!req || wr) |=> (rdata == '0));

endmodule

// File: tb/dbs_top_tb_top.sv
module dbs_top_tb_top;
   localparam int AW   = 6;
   localparam int LW   = 8;
   localparam int RW   = AW - 1;
   localparam int ROWS = 1 << RW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req, wr, size;
   logic [AW-1:0] addr;
   logic [15:0]   wdata, rdata;
   logic [RW-1:0] b0_row, b1_row;
   logic          b0_cs, b0_we, b1_cs, b1_we;
   logic [7:0]    b0_wdata, b1_wdata, b0_rdata, b1_rdata;

   always #4 clk = ~clk;

   dbs_top #(.ADDR_W(AW), .LANE_W(LW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .size(size),
      .addr(addr), .wdata(wdata), .rdata(rdata),
      .b0_row(b0_row), .b0_cs(b0_cs), .b0_we(b0_we),
      .b0_wdata(b0_wdata), .b0_rdata(b0_rdata),
      .b1_row(b1_row), .b1_cs(b1_cs), .b1_we(b1_we),
      .b1_wdata(b1_wdata), .b1_rdata(b1_rdata)
   );

   // Synchronous bank models
   logic [7:0] m0 [ROWS];
   logic [7:0] m1 [ROWS];
   always @(posedge clk) begin
      if (b0_cs) begin
         if (b0_we) m0[b0_row] <= b0_wdata;
         b0_rdata <= m0[b0_row];
      end
      if (b1_cs) begin
         if (b1_we) m1[b1_row] <= b1_wdata;
         b1_rdata <= m1[b1_row];
      end
   end

   int nchk = 0;
   int nbad = 0;
   bit done = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
         $finish;
      end
   endtask

   // {wr, size, addr[5:0], wdata[15:0], expected rdata[15:0]}
   localparam int NV = 16;
   localparam logic [39:0] VEC [NV] = '{
      {1'b1, 1'b1, 6'h04, 16'h1122, 16'h0000},
      {1'b1, 1'b1, 6'h07, 16'h3344, 16'h0000},
      {1'b1, 1'b0, 6'h0A, 16'hFF55, 16'h0000},
      {1'b1, 1'b0, 6'h0B, 16'hEE66, 16'h0000},
      {1'b1, 1'b1, 6'h3F, 16'h7788, 16'h0000},
      {1'b0, 1'b1, 6'h04, 16'h0000, 16'h1122},
      {1'b0, 1'b1, 6'h07, 16'h0000, 16'h3344},
      {1'b0, 1'b1, 6'h0A, 16'h0000, 16'h5566},
      {1'b0, 1'b0, 6'h0B, 16'h0000, 16'h0066},
      {1'b0, 1'b0, 6'h08, 16'h0000, 16'h0044},
      {1'b0, 1'b1, 6'h3F, 16'h0000, 16'h7788},
      {1'b0, 1'b0, 6'h00, 16'h0000, 16'h0088},
      {1'b0, 1'b1, 6'h06, 16'h0000, 16'h0033},
      {1'b0, 1'b0, 6'h05, 16'h0000, 16'h0022},
      {1'b1, 1'b0, 6'h05, 16'hAB99, 16'h0000},
      {1'b0, 1'b1, 6'h04, 16'h0000, 16'h1199}
   };

   // Drive one access at the falling edge, check bank controls mid-cycle,
   // then check rdata just after the rising edge that launched the banks.
   task automatic access(input logic w, input logic s, input logic [AW-1:0] a,
                         input logic [15:0] d, input logic [15:0] exp_rd);
      logic [1:0]    ecs;
      logic [RW-1:0] er0, er1;
      @(negedge clk);
      req = 1'b1; wr = w; size = s; addr = a; wdata = d;
      #2;
      ecs = s ? 2'b11 : (a[0] ? 2'b10 : 2'b01);
      er1 = a[AW-1:1];
      er0 = (s && a[0]) ? RW'(a[AW-1:1] + 1) : a[AW-1:1];
      chk("R1 cs", {30'd0, b1_cs, b0_cs}, {30'd0, ecs});
      chk("R7 we", {30'd0, b1_we, b0_we}, {30'd0, ecs & {2{w}}});
      if (ecs[0]) chk("R3 b0_row", 32'(b0_row), 32'(er0));
      if (ecs[1]) chk("R3 b1_row", 32'(b1_row), 32'(er1));
      if (w && s && !a[0]) chk("R4 even split", {16'd0, b0_wdata, b1_wdata}, {16'd0, d});
      if (w && s && a[0])  chk("R5 odd split",  {16'd0, b1_wdata, b0_wdata}, {16'd0, d});
      if (w && !s) chk("R6 byte lane", 32'(a[0] ? b1_wdata : b0_wdata), 32'(d[7:0]));
      @(posedge clk);
      #1;
      if (w)      chk("R10 rdata after write", 32'(rdata), 32'(exp_rd));
      else if (s) chk("R8 half read", 32'(rdata), 32'(exp_rd));
      else        chk("R9 byte read", 32'(rdata), 32'(exp_rd));
   endtask

   initial begin
      #(8 * 200000);
      nbad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      for (int i = 0; i < ROWS; i++) begin
         m0[i] = 8'h00;
         m1[i] = 8'h00;
      end
      b0_rdata = 8'h00; b1_rdata = 8'h00;
      rst_n = 1'b0; req = 1'b0; wr = 1'b0; size = 1'b0; addr = '0; wdata = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R12 rdata in reset", 32'(rdata), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R12 rdata after reset", 32'(rdata), 32'd0);
      chk("R2 idle cs", {30'd0, b1_cs, b0_cs}, 32'd0);

      for (int v = 0; v < NV; v++) begin
         access(VEC[v][39], VEC[v][38], VEC[v][37:32], VEC[v][31:16], VEC[v][15:0]);
      end

      // R11: wrap at the top byte address, checked at the bank ports
      @(negedge clk);
      req = 1'b1; wr = 1'b0; size = 1'b1; addr = 6'h3F;
      #2;
      chk("R11 wrap b0 row", 32'(b0_row), 32'd0);
      chk("R11 wrap b1 row", 32'(b1_row), 32'(ROWS - 1));

      // R2: write strobe without request leaves memory intact
      @(negedge clk);
      req = 1'b0; wr = 1'b1; size = 1'b1; addr = 6'h04; wdata = 16'hDEAD;
      #2;
      chk("R2 no req cs/we", {28'd0, b1_cs, b0_cs, b1_we, b0_we}, 32'd0);
      @(posedge clk);
      #1;
      chk("R10 rdata after idle", 32'(rdata), 32'd0);
      access(1'b0, 1'b1, 6'h04, 16'h0000, 16'h1199);

      // R6: upper lane of a byte write does not reach the neighbour byte
      access(1'b1, 1'b0, 6'h10, 16'hC3A5, 16'h0000);
      access(1'b0, 1'b1, 6'h10, 16'h0000, 16'hA500);

      @(negedge clk);
      req = 1'b0;
      @(posedge clk);
      #1;
      chk("R10 rdata idle end", 32'(rdata), 32'd0);
      finish_run();
   end

endmodule